// File: doc/BRIEF.md
# Adjacent instruction pair fusion detector

This block sits at the end of instruction decode and looks at a decode group of six 32-bit RV64 instruction words per cycle, each with its own valid bit. For every pair of neighbouring slots (0/1, 1/2, 2/3, 3/4 and 4/5) it decides whether the two words form one of a fixed set of shift, add and mask idioms. A pair that qualifies is replaced by one fused micro-operation. The block reports a fused operation code and the destination and source registers of that operation. The second slot of the pair is marked consumed, so it issues nothing of its own.

Each pair has its own matcher, and all five work in parallel. A left-to-right priority chain then resolves overlaps, so that no instruction ends up in two fused pairs. The results are registered, so they appear one clock after the group is presented. Downstream logic uses the per-slot issue mask together with the per-pair fuse outputs. Compressed encodings are not recognised.

Top module: `fuse_pair_detect`

## Requirements
- R1: Slot s occupies `in_instr[32*s+31:32*s]`, decoded with the base RV64 field layout: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25], imm [31:20]. Only slots s and s+1 form pair s. Two idiom halves separated by another slot never fuse.
- R2: A pair fuses only when both of its slots have their valid bit set.
- R3: A pair fuses only when the second instruction writes the same rd as the first, the second reads that rd as its consuming source (rs1 for shifts, masks, zext.h and sext.h), and that rd is not x0.
- R4: Shift-pair codes. slli 32 followed by srli 32 gives 1. slli 48 followed by srli 48 gives 2. slliw 16 followed by srliw 16 gives 3. slliw 16 followed by sraiw 16 gives 4. slli 32 followed by srli 31, 30 or 29 gives 13, 14 or 15. For these codes the fused rs2 is 0. `out_fuse[k]` is set exactly when `out_op` field k is non-zero.
- R5: slli by 1, 2, 3 or 4 followed by add gives 5, 6, 7 or 8. srli by 29, 30, 31 or 32 followed by add gives 9, 10, 11 or 12. Exactly one add operand must be the intermediate rd, in either operand position. The fused rs2 is the other add operand.
- R6: srli 8 followed by andi 255 gives 16, with fused rs2 = 0. andi 1 followed by add gives 17, and andi 1 followed by addw gives 18. For 17 and 18 the fused rs2 is the other operand. Any other shift amount or mask value does not fuse.
- R7: addw followed by one of the following gives a fused op whose rs2 is the addw's rs2: andi 255 gives 19, andi 1 gives 20, zext.h (OP-32, funct3 4, funct7 0000100, rs2 0) gives 21, and sext.h (OP-IMM, funct3 1, imm 0x605) gives 22.
- R8: When overlapping pairs both qualify, the lower-indexed pair wins. No slot belongs to two fused pairs.
- R9: `out_issue[s]` is 1 exactly when slot s is valid and is not the second slot of a fused pair.
- R10: All outputs are 0 while `rst_n` is low. Otherwise the outputs reflect the inputs sampled at the previous rising clock edge. The fused rd and rs1 of pair k are the first instruction's rd and rs1. The register fields of an unfused pair are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 6 | Valid bit per slot |
| in_instr | input | 192 | Six 32-bit instruction words, slot 0 in the low bits |
| out_fuse | output | 5 | Pair k fused |
| out_op | output | 25 | Fused operation code per pair, 5 bits each |
| out_rd | output | 25 | Fused destination register per pair |
| out_rs1 | output | 25 | Fused first source per pair |
| out_rs2 | output | 25 | Fused second source per pair |
| out_issue | output | 6 | Slot still issues its own operation |

## Verification
Several properties are checked on every cycle:
- a fuse never follows a pair with a missing valid bit;
- a fused destination is never x0;
- the fuse flag agrees with a non-zero op code;
- no slot is claimed by two neighbouring pairs;
- a consumed slot never issues;
- an issuing slot was valid one cycle earlier.

Only the bench scenarios can show the rest. These cover:
- that each of the 22 idioms maps to its own code at every pair position, with the right registers;
- that near misses stay unfused: wrong shift amounts, wrong masks, mismatched registers, x0 destinations and separated halves;
- which of two overlapping pairs wins.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

   localparam int unsigned FUSE_ILEN  = 32;
   localparam int unsigned FUSE_REG_W = 5;
   localparam int unsigned FUSE_OP_W  = 5;

   typedef enum logic [FUSE_OP_W-1:0] {
      FOP_NONE      = 5'd0,
      FOP_LZEXT32   = 5'd1,
      FOP_LZEXT16   = 5'd2,
      FOP_ZEXTH     = 5'd3,
      FOP_SEXTH     = 5'd4,
      FOP_SLADD1    = 5'd5,
      FOP_SLADD2    = 5'd6,
      FOP_SLADD3    = 5'd7,
      FOP_SLADD4    = 5'd8,
      FOP_SRADD29   = 5'd9,
      FOP_SRADD30   = 5'd10,
      FOP_SRADD31   = 5'd11,
      FOP_SRADD32   = 5'd12,
      FOP_ZWSL1     = 5'd13,
      FOP_ZWSL2     = 5'd14,
      FOP_ZWSL3     = 5'd15,
      FOP_BYTE1     = 5'd16,
      FOP_ODDADD    = 5'd17,
      FOP_ODDADDW   = 5'd18,
      FOP_ADDWBYTE  = 5'd19,
      FOP_ADDWBIT   = 5'd20,
      FOP_ADDWZEXTH = 5'd21,
      FOP_ADDWSEXTH = 5'd22
   } fuse_op_e;

   typedef struct packed {
      logic [FUSE_REG_W-1:0] rd;
      logic [FUSE_REG_W-1:0] rs1;
      logic [FUSE_REG_W-1:0] rs2;
      logic [5:0]            shamt;
      logic [11:0]           imm;
      logic                  slli;
      logic                  srli;
      logic                  slliw;
      logic                  srliw;
      logic                  sraiw;
      logic                  andi;
      logic                  add;
      logic                  addw;
      logic                  zexth;
      logic                  sexth;
   } dec_t;

endpackage

// File: rtl/fuse_field_decode.sv
module fuse_field_decode
   import fuse_pkg::*;
(
   input  logic [FUSE_ILEN-1:0] instr,
   output dec_t                 dec
);

   localparam logic [6:0] OPC_IMM   = 7'h13;
   localparam logic [6:0] OPC_IMM32 = 7'h1B;
   localparam logic [6:0] OPC_REG   = 7'h33;
   localparam logic [6:0] OPC_REG32 = 7'h3B;

   logic [6:0]  opc;
   logic [2:0]  f3;
   logic [6:0]  f7;
   logic [11:0] imm;

   assign opc = instr[6:0];
   assign f3  = instr[14:12];
   assign f7  = instr[31:25];
   assign imm = instr[31:20];

   always_comb begin
      dec.rd    = instr[11:7];
      dec.rs1   = instr[19:15];
      dec.rs2   = instr[24:20];
      dec.shamt = instr[25:20];
      dec.imm   = imm;
      dec.slli  = (opc == OPC_IMM)   && (f3 == 3'd1) && (imm[11:6] == 6'd0);
      dec.srli  = (opc == OPC_IMM)   && (f3 == 3'd5) && (imm[11:6] == 6'd0);
      dec.andi  = (opc == OPC_IMM)   && (f3 == 3'd7);
      dec.sexth = (opc == OPC_IMM)   && (f3 == 3'd1) && (imm == 12'h605);
      dec.slliw = (opc == OPC_IMM32) && (f3 == 3'd1) && (f7 == 7'b0000000);
      dec.srliw = (opc == OPC_IMM32) && (f3 == 3'd5) && (f7 == 7'b0000000);
      dec.sraiw = (opc == OPC_IMM32) && (f3 == 3'd5) && (f7 == 7'b0100000);
      dec.add   = (opc == OPC_REG)   && (f3 == 3'd0) && (f7 == 7'b0000000);
      dec.addw  = (opc == OPC_REG32) && (f3 == 3'd0) && (f7 == 7'b0000000);
      dec.zexth = (opc == OPC_REG32) && (f3 == 3'd4) && (f7 == 7'b0000100)
                  && (instr[24:20] == 5'd0);
   end

endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
   import fuse_pkg::*;
(
   input  dec_t                  a,
   input  dec_t                  b,
   input  logic                  a_valid,
   input  logic                  b_valid,
   output logic                  hit,
   output fuse_op_e              op,
   output logic [FUSE_REG_W-1:0] rd,
   output logic [FUSE_REG_W-1:0] rs1,
   output logic [FUSE_REG_W-1:0] rs2
);

   logic                  chain;
   logic                  use1;
   logic                  use2;
   logic                  add_one;
   logic                  addw_one;
   logic [FUSE_REG_W-1:0] other;
   fuse_op_e              code;
   logic [FUSE_REG_W-1:0] code_rs2;
   logic                  unused_bits;

   assign unused_bits = ^{a.srliw, a.sraiw, a.add, a.zexth, a.sexth, b.slli, b.slliw};

   assign chain    = a_valid && b_valid && (a.rd != '0) && (b.rd == a.rd);
   assign use1     = (b.rs1 == a.rd);
   assign use2     = (b.rs2 == a.rd);
   assign add_one  = b.add  && (use1 ^ use2);
   assign addw_one = b.addw && (use1 ^ use2);
   assign other    = use1 ? b.rs2 : b.rs1;

   always_comb begin
      code     = FOP_NONE;
      code_rs2 = '0;
      if (a.slli && b.srli && use1) begin
         if (a.shamt == 6'd32) begin
            case (b.shamt)
               6'd32:   code = FOP_LZEXT32;
               6'd31:   code = FOP_ZWSL1;
               6'd30:   code = FOP_ZWSL2;
               6'd29:   code = FOP_ZWSL3;
               default: code = FOP_NONE;
            endcase
         end else if (a.shamt == 6'd48 && b.shamt == 6'd48) begin
            code = FOP_LZEXT16;
         end
      end else if (a.slliw && a.shamt == 6'd16 && use1 && b.shamt == 6'd16
                   && (b.srliw || b.sraiw)) begin
         code = b.srliw ? FOP_ZEXTH : FOP_SEXTH;
      end else if (a.slli && add_one) begin
         code_rs2 = other;
         case (a.shamt)
            6'd1:    code = FOP_SLADD1;
            6'd2:    code = FOP_SLADD2;
            6'd3:    code = FOP_SLADD3;
            6'd4:    code = FOP_SLADD4;
            default: code = FOP_NONE;
         endcase
      end else if (a.srli && add_one) begin
         code_rs2 = other;
         case (a.shamt)
            6'd29:   code = FOP_SRADD29;
            6'd30:   code = FOP_SRADD30;
            6'd31:   code = FOP_SRADD31;
            6'd32:   code = FOP_SRADD32;
            default: code = FOP_NONE;
         endcase
      end else if (a.srli && a.shamt == 6'd8 && b.andi && use1 && b.imm == 12'd255) begin
         code = FOP_BYTE1;
      end else if (a.andi && a.imm == 12'd1 && (add_one || addw_one)) begin
         code     = add_one ? FOP_ODDADD : FOP_ODDADDW;
         code_rs2 = other;
      end else if (a.addw && use1) begin
         code_rs2 = a.rs2;
         if (b.andi && b.imm == 12'd255)    code = FOP_ADDWBYTE;
         else if (b.andi && b.imm == 12'd1) code = FOP_ADDWBIT;
         else if (b.zexth)                  code = FOP_ADDWZEXTH;
         else if (b.sexth)                  code = FOP_ADDWSEXTH;
      end
   end

   always_comb begin
      hit = chain && (code != FOP_NONE);
      op  = hit ? code : FOP_NONE;
      rd  = hit ? a.rd : '0;
      rs1 = hit ? a.rs1 : '0;
      rs2 = hit ? code_rs2 : '0;
   end

endmodule

// File: rtl/fuse_pair_priority.sv
module fuse_pair_priority #(
   parameter int unsigned NUM_PAIRS = 5
) (
   input  logic [NUM_PAIRS-1:0] cand,
   output logic [NUM_PAIRS-1:0] grant
);

   assign grant[0] = cand[0];

   for (genvar k = 1; k < NUM_PAIRS; k++) begin : g_chain
      assign grant[k] = cand[k] && !grant[k-1];
   end

endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
   import fuse_pkg::*;
#(
   parameter int unsigned NUM_SLOTS    = 6,
   parameter int unsigned INSTR_W      = 32,
   parameter bit          REGISTER_OUT = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_SLOTS-1:0]                in_valid,
   input  logic [NUM_SLOTS*INSTR_W-1:0]        in_instr,
   output logic [NUM_SLOTS-2:0]                out_fuse,
   output logic [(NUM_SLOTS-1)*FUSE_OP_W-1:0]  out_op,
   output logic [(NUM_SLOTS-1)*FUSE_REG_W-1:0] out_rd,
   output logic [(NUM_SLOTS-1)*FUSE_REG_W-1:0] out_rs1,
   output logic [(NUM_SLOTS-1)*FUSE_REG_W-1:0] out_rs2,
   output logic [NUM_SLOTS-1:0]                out_issue
);

   localparam int unsigned NUM_PAIRS = NUM_SLOTS - 1;
   localparam int unsigned OPW       = FUSE_OP_W;
   localparam int unsigned RW        = FUSE_REG_W;

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("fuse_pair_detect needs at least two slots");
   end
   if (INSTR_W != FUSE_ILEN) begin : g_bad_width
      $error("fuse_pair_detect handles only 32-bit instruction words");
   end

   dec_t                   dec   [NUM_SLOTS];
   fuse_op_e               c_op  [NUM_PAIRS];
   logic [RW-1:0]          c_rd  [NUM_PAIRS];
   logic [RW-1:0]          c_rs1 [NUM_PAIRS];
   logic [RW-1:0]          c_rs2 [NUM_PAIRS];
   logic [NUM_PAIRS-1:0]   cand;
   logic [NUM_PAIRS-1:0]   grant;
   logic [NUM_SLOTS-1:0]   consumed;
   logic [NUM_PAIRS*OPW-1:0] n_op;
   logic [NUM_PAIRS*RW-1:0]  n_rd;
   logic [NUM_PAIRS*RW-1:0]  n_rs1;
   logic [NUM_PAIRS*RW-1:0]  n_rs2;
   logic [NUM_SLOTS-1:0]   n_issue;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      fuse_field_decode u_dec (
         .instr (in_instr[s*INSTR_W +: INSTR_W]),
         .dec   (dec[s])
      );
   end

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      fuse_pair_match u_match (
         .a       (dec[k]),
         .b       (dec[k+1]),
         .a_valid (in_valid[k]),
         .b_valid (in_valid[k+1]),
         .hit     (cand[k]),
         .op      (c_op[k]),
         .rd      (c_rd[k]),
         .rs1     (c_rs1[k]),
         .rs2     (c_rs2[k])
      );
      assign n_op[k*OPW +: OPW] = grant[k] ? c_op[k]  : FOP_NONE;
      assign n_rd[k*RW +: RW]   = grant[k] ? c_rd[k]  : '0;
      assign n_rs1[k*RW +: RW]  = grant[k] ? c_rs1[k] : '0;
      assign n_rs2[k*RW +: RW]  = grant[k] ? c_rs2[k] : '0;
      assign consumed[k+1]      = grant[k];
   end

   assign consumed[0] = 1'b0;
   assign n_issue     = in_valid & ~consumed;

   fuse_pair_priority #(.NUM_PAIRS(NUM_PAIRS)) u_prio (
      .cand  (cand),
      .grant (grant)
   );

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_fuse  <= '0;
            out_op    <= '0;
            out_rd    <= '0;
            out_rs1   <= '0;
            out_rs2   <= '0;
            out_issue <= '0;
         end else begin
            out_fuse  <= grant;
            out_op    <= n_op;
            out_rd    <= n_rd;
            out_rs1   <= n_rs1;
            out_rs2   <= n_rs2;
            out_issue <= n_issue;
         end
      end

      for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_chk_pair
         p_pair_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid[k] && in_valid[k+1]) |=> !out_fuse[k]);
         p_rd_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_fuse[k] |-> (out_rd[k*RW +: RW] != '0));
         p_flag_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_fuse[k] == (out_op[k*OPW +: OPW] != '0));
         p_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_fuse[k] |-> !out_issue[k+1]);
         if (k + 1 < NUM_PAIRS) begin : g_owner
            p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
               !(out_fuse[k] && out_fuse[k+1]));
         end
      end

      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk_slot
         p_issue_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_issue[s] |-> $past(in_valid[s]));
      end
   end else begin : g_comb
      assign out_fuse  = grant;
      assign out_op    = n_op;
      assign out_rd    = n_rd;
      assign out_rs1   = n_rs1;
      assign out_rs2   = n_rs2;
      assign out_issue = n_issue;
   end

endmodule

// File: tb/test_fuse_pair_detect.sv
`timescale 1ns/1ps
module test_fuse_pair_detect;

   localparam logic [31:0] NOP = 32'h0000_0013;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [5:0]   vld = '0;
   logic [191:0] ins = '0;
   logic [4:0]   o_fuse;
   logic [24:0]  o_op, o_rd, o_rs1, o_rs2;
   logic [5:0]   o_issue;
   int           n_checks = 0;
   int           n_fail = 0;
   bit           done = 0;

   always #2 clk = ~clk;

   fuse_pair_detect i_fuse_pair_detect (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_instr(ins),
      .out_fuse(o_fuse), .out_op(o_op), .out_rd(o_rd), .out_rs1(o_rs1),
      .out_rs2(o_rs2), .out_issue(o_issue)
   );

   function automatic logic [31:0] enc_i(input logic [6:0] opc, input logic [2:0] f3,
                                         input logic [4:0] rd, input logic [4:0] rs,
                                         input logic [11:0] imm);
      return {imm, rs, f3, rd, opc};
   endfunction
   function automatic logic [31:0] enc_r(input logic [6:0] opc, input logic [2:0] f3,
                                         input logic [6:0] f7, input logic [4:0] rd,
                                         input logic [4:0] a, input logic [4:0] b);
      return {f7, b, a, f3, rd, opc};
   endfunction
   function automatic logic [31:0] slli(input logic [4:0] rd, rs, input logic [5:0] sh);
      return enc_i(7'h13, 3'd1, rd, rs, {6'd0, sh});
   endfunction
   function automatic logic [31:0] srli(input logic [4:0] rd, rs, input logic [5:0] sh);
      return enc_i(7'h13, 3'd5, rd, rs, {6'd0, sh});
   endfunction
   function automatic logic [31:0] andi(input logic [4:0] rd, rs, input logic [11:0] im);
      return enc_i(7'h13, 3'd7, rd, rs, im);
   endfunction
   function automatic logic [31:0] slliw(input logic [4:0] rd, rs, input logic [4:0] sh);
      return enc_i(7'h1B, 3'd1, rd, rs, {7'd0, sh});
   endfunction
   function automatic logic [31:0] srliw(input logic [4:0] rd, rs, input logic [4:0] sh);
      return enc_i(7'h1B, 3'd5, rd, rs, {7'd0, sh});
   endfunction
   function automatic logic [31:0] sraiw(input logic [4:0] rd, rs, input logic [4:0] sh);
      return enc_i(7'h1B, 3'd5, rd, rs, {7'b0100000, sh});
   endfunction
   function automatic logic [31:0] add(input logic [4:0] rd, a, b);
      return enc_r(7'h33, 3'd0, 7'd0, rd, a, b);
   endfunction
   function automatic logic [31:0] addw(input logic [4:0] rd, a, b);
      return enc_r(7'h3B, 3'd0, 7'd0, rd, a, b);
   endfunction
   function automatic logic [31:0] zexth(input logic [4:0] rd, rs);
      return enc_r(7'h3B, 3'd4, 7'b0000100, rd, rs, 5'd0);
   endfunction
   function automatic logic [31:0] sexth(input logic [4:0] rd, rs);
      return enc_i(7'h13, 3'd1, rd, rs, 12'h605);
   endfunction

   // idiom j has expected op code j+1; first source x1, other source x2
   task automatic idiom(input int j, output logic [31:0] a, output logic [31:0] b,
                        output logic [4:0] rd, output logic [4:0] rs2x, output string req);
      rd   = 5'(j + 3);
      rs2x = 5'd0;
      a    = NOP;
      b    = NOP;
      if (j == 0) begin a = slli(rd, 1, 32); b = srli(rd, rd, 32); req = "R4"; end
      else if (j == 1) begin a = slli(rd, 1, 48); b = srli(rd, rd, 48); req = "R4"; end
      else if (j == 2) begin a = slliw(rd, 1, 16); b = srliw(rd, rd, 16); req = "R4"; end
      else if (j == 3) begin a = slliw(rd, 1, 16); b = sraiw(rd, rd, 16); req = "R4"; end
      else if (j <= 7) begin
         a = slli(rd, 1, 6'(j - 3));
         b = (j % 2 == 1) ? add(rd, 2, rd) : add(rd, rd, 2);
         rs2x = 5'd2; req = "R5";
      end else if (j <= 11) begin
         a = srli(rd, 1, 6'(29 + j - 8)); b = add(rd, rd, 2); rs2x = 5'd2; req = "R5";
      end else if (j <= 14) begin
         a = slli(rd, 1, 32); b = srli(rd, rd, 6'(31 - (j - 12))); req = "R4";
      end else if (j == 15) begin a = srli(rd, 1, 8); b = andi(rd, rd, 255); req = "R6"; end
      else if (j == 16) begin a = andi(rd, 1, 1); b = add(rd, rd, 2); rs2x = 2; req = "R6"; end
      else if (j == 17) begin a = andi(rd, 1, 1); b = addw(rd, 2, rd); rs2x = 2; req = "R6"; end
      else begin
         a = addw(rd, 1, 2); rs2x = 5'd2; req = "R7";
         if (j == 18) b = andi(rd, rd, 255);
         else if (j == 19) b = andi(rd, rd, 1);
         else if (j == 20) b = zexth(rd, rd);
         else b = sexth(rd, rd);
      end
   endtask

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic apply();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic fill_nops();
      for (int s = 0; s < 6; s++) ins[s*32 +: 32] = NOP;
      vld = 6'h3F;
   endtask

   task automatic expect_none(input string what, input logic [5:0] exp_issue);
      apply();
      check({what, " fuse"}, 64'(o_fuse), 64'd0);
      check({what, " op"}, 64'(o_op), 64'd0);
      check({what, " issue"}, 64'(o_issue), 64'(exp_issue));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      logic [31:0] a, b;
      logic [4:0]  rd, rs2x;
      string       req;
      logic [24:0] e_op, e_rd, e_rs1, e_rs2;

      // R10: reset holds every output at zero even with a fusable group present
      idiom(0, a, b, rd, rs2x, req);
      fill_nops();
      ins[31:0] = a; ins[63:32] = b;
      repeat (3) @(negedge clk);
      check("R10 reset fuse", 64'(o_fuse), 64'd0);
      check("R10 reset issue", 64'(o_issue), 64'd0);
      check("R10 reset op", 64'(o_op), 64'd0);
      rst_n = 1'b1;

      // R4 R5 R6 R7 R10: every idiom at every pair position
      for (int j = 0; j < 22; j++) begin
         for (int p = 0; p < 5; p++) begin
            idiom(j, a, b, rd, rs2x, req);
            fill_nops();
            ins[p*32 +: 32]     = a;
            ins[(p+1)*32 +: 32] = b;
            apply();
            e_op = '0; e_rd = '0; e_rs1 = '0; e_rs2 = '0;
            e_op[p*5 +: 5]  = 5'(j + 1);
            e_rd[p*5 +: 5]  = rd;
            e_rs1[p*5 +: 5] = 5'd1;
            e_rs2[p*5 +: 5] = rs2x;
            check({req, " fuse flag"}, 64'(o_fuse), 64'(5'b1 << p));
            check({req, " op code"}, 64'(o_op), 64'(e_op));
            check({"R10 fused rd"}, 64'(o_rd), 64'(e_rd));
            check({"R10 fused rs1"}, 64'(o_rs1), 64'(e_rs1));
            check({req, " fused rs2"}, 64'(o_rs2), 64'(e_rs2));
            check({"R9 issue mask"}, 64'(o_issue), 64'(6'h3F & ~(6'b1 << (p + 1))));
         end
      end

      // R4 R5 R6: wrong shift amounts and masks
      fill_nops(); ins[31:0] = slli(5, 1, 32); ins[63:32] = srli(5, 5, 33);
      expect_none("R4 srli 33", 6'h3F);
      fill_nops(); ins[31:0] = slli(5, 1, 48); ins[63:32] = srli(5, 5, 47);
      expect_none("R4 shift 48/47", 6'h3F);
      fill_nops(); ins[31:0] = slliw(5, 1, 16); ins[63:32] = srliw(5, 5, 15);
      expect_none("R4 srliw 15", 6'h3F);
      fill_nops(); ins[31:0] = slli(5, 1, 5); ins[63:32] = add(5, 5, 2);
      expect_none("R5 slli 5 add", 6'h3F);
      fill_nops(); ins[31:0] = srli(5, 1, 28); ins[63:32] = add(5, 5, 2);
      expect_none("R5 srli 28 add", 6'h3F);
      fill_nops(); ins[31:0] = slli(5, 1, 1); ins[63:32] = add(5, 5, 5);
      expect_none("R5 both operands", 6'h3F);
      fill_nops(); ins[31:0] = srli(5, 1, 8); ins[63:32] = andi(5, 5, 254);
      expect_none("R6 mask 254", 6'h3F);
      fill_nops(); ins[31:0] = andi(5, 1, 3); ins[63:32] = add(5, 5, 2);
      expect_none("R6 andi 3", 6'h3F);
      fill_nops(); ins[31:0] = addw(5, 1, 2); ins[63:32] = andi(5, 5, 3);
      expect_none("R7 addw andi 3", 6'h3F);

      // R3: register mismatches and x0
      fill_nops(); ins[31:0] = slli(5, 1, 32); ins[63:32] = srli(6, 5, 32);
      expect_none("R3 rd mismatch", 6'h3F);
      fill_nops(); ins[31:0] = slli(5, 1, 32); ins[63:32] = srli(5, 6, 32);
      expect_none("R3 source mismatch", 6'h3F);
      fill_nops(); ins[31:0] = addw(5, 1, 2); ins[63:32] = andi(5, 6, 255);
      expect_none("R3 addw source", 6'h3F);
      fill_nops(); ins[31:0] = slli(0, 1, 32); ins[63:32] = srli(0, 0, 32);
      expect_none("R3 rd x0", 6'h3F);

      // R1: separated halves
      fill_nops(); ins[31:0] = slli(5, 1, 32); ins[95:64] = srli(5, 5, 32);
      expect_none("R1 non-adjacent", 6'h3F);

      // R2: a missing valid bit blocks fusion; R9 invalid slot does not issue
      fill_nops(); ins[31:0] = slli(5, 1, 32); ins[63:32] = srli(5, 5, 32);
      vld = 6'b111101;
      expect_none("R2 second invalid", 6'b111101);
      fill_nops(); ins[31:0] = slli(5, 1, 32); ins[63:32] = srli(5, 5, 32);
      vld = 6'b111110;
      expect_none("R2 first invalid", 6'b111110);

      // R8: overlapping candidates, lower pair wins
      fill_nops();
      ins[31:0] = andi(5, 1, 1); ins[63:32] = addw(5, 5, 2); ins[95:64] = andi(5, 5, 255);
      apply();
      check("R8 overlap fuse", 64'(o_fuse), 64'(5'b00001));
      check("R8 overlap op", 64'(o_op), 64'(25'd18));
      check("R9 overlap issue", 64'(o_issue), 64'(6'b111101));
      fill_nops();
      ins[63:32] = andi(5, 1, 1); ins[95:64] = addw(5, 5, 2); ins[127:96] = andi(5, 5, 255);
      apply();
      check("R8 shifted overlap fuse", 64'(o_fuse), 64'(5'b00010));
      check("R8 shifted overlap op", 64'(o_op), 64'(25'd18 << 5));
      check("R9 shifted overlap issue", 64'(o_issue), 64'(6'b111011));

      // R8 R9: three disjoint pairs in one group
      fill_nops();
      ins[31:0] = slli(5, 1, 32);   ins[63:32]   = srli(5, 5, 32);
      ins[95:64] = slli(6, 1, 2);   ins[127:96]  = add(6, 6, 2);
      ins[159:128] = addw(7, 1, 2); ins[191:160] = sexth(7, 7);
      apply();
      check("R8 three pairs fuse", 64'(o_fuse), 64'(5'b10101));
      check("R8 three pairs op", 64'(o_op), 64'({5'd22, 5'd0, 5'd6, 5'd0, 5'd1}));
      check("R9 three pairs issue", 64'(o_issue), 64'(6'b010101));

      // R10: dropping the group clears outputs one cycle later
      vld = 6'h00;
      expect_none("R10 idle", 6'h00);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule